// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This unit holds a 16-bit compare value and checks it against a free-running 16-bit timer value on every clock cycle. When the two become equal, the unit acts on a single output latch that drives a pin. Depending on a 4-bit mode code, the latch goes low, goes high or toggles, or the pin is left alone. In every case a sticky match flag is raised, and software clears it.

Software loads the compare value one byte at a time. It picks the action by writing a mode code. The clear-on-match and set-on-match codes preset the latch to the level opposite to the one the match will drive, so every match gives a visible edge. A match counts only on the cycle where equality first appears, so a timer that stops on the compare value fires once. The timer source itself lies outside this unit.

Top module: `cmp_match_unit`

## Requirements
- R1: After reset the pin output is 0, the match flag is 0, the compare value is 0 and the mode is off.
- R2: In mode 4'b1000, a match drives the pin to 0 and sets the flag. Writing 4'b1000 presets the pin to 1 on the next cycle.
- R3: The flag is set on the same clock edge as the match action and stays set until a flag-clear pulse is applied.
- R4: In mode 4'b1001, a match drives the pin to 1 and sets the flag. Writing 4'b1001 presets the pin to 0 on the next cycle.
- R5: In mode 4'b1010, a match sets the flag and leaves the pin unchanged. Writing 4'b1010 does not change the pin.
- R6: In mode 4'b1011, each match inverts the pin. Writing 4'b1011 does not change the pin.
- R7: A match is acted on only in the cycle where equality starts. If the timer stays equal to the compare value, the unit neither toggles again nor sets the flag again.
- R8: Mode 4'b0000, and any code outside 4'b1000 to 4'b1011, turns the unit off. Writing it forces the pin to 0, and while the unit is off, matches set no flag.
- R9: A flag-clear pulse in the same cycle as a new match leaves the flag set.
- R10: A compare byte write (low byte = bits 7:0, high byte = bits 15:8) takes part in the comparison from the cycle after the write. A match that the write creates is acted on at the following edge.
- R11: When timer and compare value differ, the pin and the flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_val | input | 16 | Current timer count |
| cmp_lo_we | input | 1 | Write `wr_byte` into compare bits 7:0 |
| cmp_hi_we | input | 1 | Write `wr_byte` into compare bits 15:8 |
| wr_byte | input | 8 | Byte for compare writes |
| mode_we | input | 1 | Load `mode_in` into the mode register |
| mode_in | input | 4 | New mode code |
| flag_clr | input | 1 | Clear the match flag |
| pin_out | output | 1 | Output latch driving the pin |
| match_flag | output | 1 | Sticky match flag |

## Verification
Each action mode is tried against a timer that steps onto the compare value from a different value. This separates the four actions and shows that each preset level comes before the edge that the match produces. A timer that stalls on the compare value checks that the unit fires once and not on every cycle. A compare value written by bytes while the timer already holds it checks the one-cycle delay of the write. A flag clear that lands on a match checks the priority between clear and set. Off mode, and timer values that differ from the compare value, check that nothing moves without a valid match.

// File: rtl/cmp_match_unit.sv
`timescale 1ns/1ps
module cmp_match_unit #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*BW-1:0] timer_val,
  input  logic          cmp_lo_we,
  input  logic          cmp_hi_we,
  input  logic [BW-1:0] wr_byte,
  input  logic          mode_we,
  input  logic [3:0]    mode_in,
  input  logic          flag_clr,
  output logic          pin_out,
  output logic          match_flag
);
  localparam int TW = 2 * BW;
  localparam logic [3:0] M_CLR  = 4'b1000;
  localparam logic [3:0] M_SET  = 4'b1001;
  localparam logic [3:0] M_FLAG = 4'b1010;
  localparam logic [3:0] M_TGL  = 4'b1011;

  logic [TW-1:0] cmp_q;
  logic [3:0]    mode_q;
  logic          eq_q;

  wire eq     = (cmp_q == timer_val);
  wire hit    = eq && !eq_q;
  wire active = mode_q[3] && !mode_q[2];
  wire fire   = hit && active && !mode_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= '0;
      eq_q   <= 1'b0;
    end else begin
      eq_q <= eq;
      if (cmp_lo_we) cmp_q[BW-1:0]  <= wr_byte;
      if (cmp_hi_we) cmp_q[TW-1:BW] <= wr_byte;
      if (mode_we)   mode_q <= mode_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= 1'b0;
    end else if (mode_we) begin
      case (mode_in)
        M_CLR:         pin_out <= 1'b1;
        M_SET:         pin_out <= 1'b0;
        M_FLAG, M_TGL: pin_out <= pin_out;
        default:       pin_out <= 1'b0;
      endcase
    end else if (fire) begin
      case (mode_q)
        M_CLR:   pin_out <= 1'b0;
        M_SET:   pin_out <= 1'b1;
        M_TGL:   pin_out <= ~pin_out;
        default: pin_out <= pin_out;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        match_flag <= 1'b0;
    else if (fire)     match_flag <= 1'b1;
    else if (flag_clr) match_flag <= 1'b0;
  end

  AST_PRESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_in == M_CLR) |=> pin_out); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clr) |=> match_flag); // R3
  AST_PRESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_in == M_SET) |=> !pin_out); // R4
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_we && eq && eq_q) |=> pin_out == $past(pin_out)); // R7
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !mode_we && !match_flag) |=> !match_flag); // R8
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && flag_clr) |=> match_flag); // R9
endmodule

// File: tb/cmp_match_unit_tb.sv
`timescale 1ns/1ps
module cmp_match_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] timer_val = 0;
  logic cmp_lo_we = 0, cmp_hi_we = 0, mode_we = 0, flag_clr = 0;
  logic [7:0] wr_byte = 0;
  logic [3:0] mode_in = 0;
  logic pin_out, match_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_match_unit dut_i (.clk, .rst_n, .timer_val, .cmp_lo_we, .cmp_hi_we,
    .wr_byte, .mode_we, .mode_in, .flag_clr, .pin_out, .match_flag);

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic set_cmp(input logic [15:0] v);
    cmp_lo_we = 1; wr_byte = v[7:0]; step();
    cmp_lo_we = 0; cmp_hi_we = 1; wr_byte = v[15:8]; step();
    cmp_hi_we = 0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_we = 1; mode_in = m; step(); mode_we = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk(pin_out, 0, "R1 pin after reset");
    chk(match_flag, 0, "R1 flag after reset");
  endtask

  task automatic t_clear_mode();
    set_cmp(16'h1234); timer_val = 16'h0000;
    set_mode(4'b1000);
    chk(pin_out, 1, "R2 preset high");
    chk(match_flag, 0, "R2 no flag on write");
    timer_val = 16'h1233; step();
    chk(pin_out, 1, "R11 no action on mismatch");
    timer_val = 16'h1234; step();
    chk(pin_out, 0, "R2 match drives low");
    chk(match_flag, 1, "R3 flag with action");
    timer_val = 16'h1300; step(3);
    chk(match_flag, 1, "R3 flag sticky");
    clear_flag();
    chk(match_flag, 0, "R3 flag cleared");
  endtask

  task automatic t_set_mode();
    timer_val = 16'h0000;
    set_mode(4'b1001);
    chk(pin_out, 0, "R4 preset low");
    timer_val = 16'h1234; step();
    chk(pin_out, 1, "R4 match drives high");
    chk(match_flag, 1, "R4 flag set");
    clear_flag();
  endtask

  task automatic t_flag_only();
    timer_val = 16'h0001;
    set_mode(4'b1010);
    chk(pin_out, 1, "R5 write keeps pin");
    timer_val = 16'h1234; step();
    chk(pin_out, 1, "R5 pin unchanged on match");
    chk(match_flag, 1, "R5 flag set");
    clear_flag();
  endtask

  task automatic t_toggle();
    timer_val = 16'h0002;
    set_mode(4'b1011);
    chk(pin_out, 1, "R6 write keeps pin");
    timer_val = 16'h1234; step();
    chk(pin_out, 0, "R6 first toggle");
    chk(match_flag, 1, "R6 flag set");
    flag_clr = 1; step(); flag_clr = 0;
    step(2);
    chk(pin_out, 0, "R7 stalled timer no retoggle");
    chk(match_flag, 0, "R7 stalled timer no reflag");
    timer_val = 16'h1235; step();
    timer_val = 16'h1234; step();
    chk(pin_out, 1, "R6 second toggle");
  endtask

  task automatic t_clear_vs_match();
    timer_val = 16'h0003; step();
    chk(match_flag, 1, "R9 flag still set before test");
    clear_flag();
    timer_val = 16'h1234; flag_clr = 1; step();
    chk(match_flag, 1, "R9 clear loses to match");
    step(); flag_clr = 0;
    chk(match_flag, 0, "R9 later clear works");
  endtask

  task automatic t_byte_write();
    timer_val = 16'h0000;
    set_mode(4'b1001);
    timer_val = 16'h00AB;
    cmp_lo_we = 1; wr_byte = 8'hAB; step(); cmp_lo_we = 0;
    chk(pin_out, 0, "R10 low byte alone no match");
    cmp_hi_we = 1; wr_byte = 8'h00; step(); cmp_hi_we = 0;
    chk(pin_out, 0, "R10 no action in write cycle");
    step();
    chk(pin_out, 1, "R10 match after write");
    chk(match_flag, 1, "R10 flag after write");
    clear_flag();
  endtask

  task automatic t_off();
    set_mode(4'b0000);
    chk(pin_out, 0, "R8 off forces low");
    timer_val = 16'h0010; step();
    timer_val = 16'h00AB; step();
    chk(match_flag, 0, "R8 no flag when off");
    chk(pin_out, 0, "R8 pin stays low when off");
    set_mode(4'b1100);
    timer_val = 16'h0011; step();
    timer_val = 16'h00AB; step();
    chk(match_flag, 0, "R8 undefined code is off");
  endtask

  initial begin
    step(3); rst_n = 1; step();
    t_reset();
    t_clear_mode();
    t_set_mode();
    t_flag_only();
    t_toggle();
    t_clear_vs_match();
    t_byte_write();
    t_off();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule